// File: doc/BRIEF.md
# Dual-Strobe BCD Decade Up/Down Counter

This block holds one decimal digit, 0 to 9, in BCD. Two strobe inputs move it: a rising edge on the up strobe adds one and a rising edge on the down strobe subtracts one. A parallel load with an active-low enable copies a 4-bit value into the digit. A master clear with an active-high level zeroes the digit at once, without waiting for a clock, and wins over every other input. Strobes rest high and give a step on their low-to-high transition.

The strobes are not used as clocks. Each strobe is sampled into the single system clock domain, passed through a parameterised register chain, and edge-detected. Two active-low terminal-count outputs let digits be chained. The carry output is low while the digit reads 9 and the up strobe is low. The borrow output is low while the digit reads 0 and the down strobe is low. When the strobe returns high, the wrap and the rising edge of the terminal-count output land on the same clock edge. Feeding one digit's carry and borrow into the next digit's up and down strobes therefore builds a multi-digit decimal counter.

Top module: `bcd_decade_updown`

## Requirements
- R1: While `clr` is high, `digit` reads 0 without waiting for a clock edge and stays 0 whatever the load and strobe inputs do. This holds from the first moment `clr` is high.
- R2: On each clock edge where `load_n` is low, `digit` takes the value of `load_val`. Strobe edges have no effect while `load_n` is low.
- R3: A rising edge on `up_stb` adds one to `digit`, and the digit goes from 9 to 0.
- R4: A rising edge on `dn_stb` subtracts one from `digit`, and the digit goes from 0 to 9.
- R5: If both strobes rise in the same clock cycle, `digit` does not change.
- R6: `carry_n` is 0 exactly when `digit` is 9 and the sampled up strobe is low. Otherwise it is 1.
- R7: `borrow_n` is 0 exactly when `digit` is 0 and the sampled down strobe is low. Otherwise it is 1.
- R8: From a loaded value of 10 to 15, an up step gives 0 and a down step gives 9.
- R9: Two digits chained carry-to-up and borrow-to-down count as a two-digit decimal counter in both directions, including the wrap from 99 to 00 and from 00 to 99.
- R10: A strobe rise that reaches the input just after a clock edge changes `digit` on the `STB_STAGES+1`-th following edge, which is the second edge with the default `STB_STAGES=1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Master clear, active high, asynchronous |
| load_n | input | 1 | Parallel load enable, active low |
| load_val | input | 4 | Value copied into the digit on load |
| up_stb | input | 1 | Count-up strobe, steps on rising edge, idles high |
| dn_stb | input | 1 | Count-down strobe, steps on rising edge, idles high |
| digit | output | 4 | Current BCD digit |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
The hardest condition to reach from the ports is a wrap on the upper digit of a chain. That digit is driven only by the lower digit's terminal-count edges, which arrive two sampling delays after the lower digit wraps. The bench chains two instances and walks them up past 09 to 15. It then walks them down by twenty through the double wrap to 95, with idle cycles so the upper digit settles. It also reaches the simultaneous-rise hold and the out-of-range load values, which ordinary counting from zero never produces, by driving both strobes low and high together and by loading 10 to 15 directly.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_LOAD = 2'd3
  } step_e;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic clr,
  input  logic stb_i,
  output logic rise_o,
  output logic lvl_o
);

  logic [STAGES-1:0] sr;
  logic              hist;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge clr) begin
        if (clr) sr <= '1;
        else     sr <= stb_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or posedge clr) begin
        if (clr) sr <= '1;
        else     sr <= {sr[STAGES-2:0], stb_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge clr) begin
    if (clr) hist <= 1'b1;
    else     hist <= sr[STAGES-1];
  end

  assign rise_o = sr[STAGES-1] & ~hist;
  assign lvl_o  = hist;

  // R10
  rise_one_cycle_chk: assert property (@(posedge clk) disable iff (clr)
    rise_o |=> !rise_o);

endmodule

// File: rtl/bcd_digit_core.sv
module bcd_digit_core
  import bcd_ctr_pkg::*;
#(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk,
  input  logic         clr,
  input  step_e        step,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOPV = W'(MAX);

  logic [W-1:0] q_nx;

  always_comb begin
    unique case (step)
      STEP_LOAD: q_nx = load_val;
      STEP_UP:   q_nx = (q >= TOPV) ? '0 : q + 1'b1;
      STEP_DN:   q_nx = (q == '0 || q > TOPV) ? TOPV : q - 1'b1;
      default:   q_nx = q;
    endcase
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) q <= '0;
    else     q <= q_nx;
  end

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (step == STEP_UP && q == TOPV) |=> q == '0);

  // R8
  oor_up_chk: assert property (@(posedge clk) disable iff (clr)
    (step == STEP_UP && q > TOPV) |=> q == '0);

  // R4
  dn_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (step == STEP_DN && q == '0) |=> q == TOPV);

endmodule

// File: rtl/bcd_decade_updown.sv
module bcd_decade_updown
  import bcd_ctr_pkg::*;
#(
  parameter int W          = 4,
  parameter int MAX        = 9,
  parameter int STB_STAGES = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  logic         up_stb,
  input  logic         dn_stb,
  output logic [W-1:0] digit,
  output logic         carry_n,
  output logic         borrow_n
);

  localparam int NSTB = 2;
  localparam logic [W-1:0] TOPV = W'(MAX);

  logic [NSTB-1:0] stb_in, stb_rise, stb_lvl;
  step_e           step;

  assign stb_in = {dn_stb, up_stb};

  generate
    for (genvar i = 0; i < NSTB; i++) begin : g_stb
      strobe_edge #(.STAGES(STB_STAGES)) u_edge (
        .clk    (clk),
        .clr    (clr),
        .stb_i  (stb_in[i]),
        .rise_o (stb_rise[i]),
        .lvl_o  (stb_lvl[i])
      );
    end
  endgenerate

  always_comb begin
    if (!load_n)                       step = STEP_LOAD;
    else if (stb_rise == 2'b01)        step = STEP_UP;
    else if (stb_rise == 2'b10)        step = STEP_DN;
    else                               step = STEP_HOLD;
  end

  bcd_digit_core #(.W(W), .MAX(MAX)) u_core (
    .clk      (clk),
    .clr      (clr),
    .step     (step),
    .load_val (load_val),
    .q        (digit)
  );

  assign carry_n  = ~((digit == TOPV) & ~stb_lvl[0]);
  assign borrow_n = ~((digit == '0)   & ~stb_lvl[1]);

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (clr)
    $fell(clr) |-> digit == '0);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (clr)
    !load_n |=> digit == $past(load_val));

  // R5
  both_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (load_n && stb_rise == 2'b11) |=> $stable(digit));

  // R6
  carry_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    ($rose(carry_n) && $past(load_n) && digit != TOPV) |-> digit == '0);

  // R7
  borrow_wrap_chk: assert property (@(posedge clk) disable iff (clr)
    ($rose(borrow_n) && $past(load_n) && digit != '0) |-> digit == TOPV);

endmodule

// File: tb/bcd_decade_updown_test.sv
module bcd_decade_updown_test;

  localparam int STG = 1;
  localparam int LAT = STG + 1;
  localparam int NV  = 12;
  // vector: op[11:10] (0 clr,1 load,2 up,3 down), data[9:6], q[5:2], mid carry_n[1], mid borrow_n[0]
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 4'd0, 4'd0, 1'b1, 1'b1},
    {2'd1, 4'd7, 4'd7, 1'b1, 1'b1},
    {2'd2, 4'd0, 4'd8, 1'b1, 1'b1},
    {2'd2, 4'd0, 4'd9, 1'b1, 1'b1},
    {2'd2, 4'd0, 4'd0, 1'b0, 1'b1},
    {2'd2, 4'd0, 4'd1, 1'b1, 1'b1},
    {2'd2, 4'd0, 4'd2, 1'b1, 1'b1},
    {2'd3, 4'd0, 4'd1, 1'b1, 1'b1},
    {2'd3, 4'd0, 4'd0, 1'b1, 1'b1},
    {2'd3, 4'd0, 4'd9, 1'b1, 1'b0},
    {2'd3, 4'd0, 4'd8, 1'b1, 1'b1},
    {2'd3, 4'd0, 4'd7, 1'b1, 1'b1}
  };

  logic clk = 0;
  always #4 clk = ~clk;

  logic       clr = 1, load_n = 1, up = 1, dn = 1;
  logic [3:0] dv = 0, q;
  logic       cn, bn;

  bcd_decade_updown #(.STB_STAGES(STG)) uut (
    .clk(clk), .clr(clr), .load_n(load_n), .load_val(dv),
    .up_stb(up), .dn_stb(dn), .digit(q), .carry_n(cn), .borrow_n(bn));

  logic       c_clr = 1, c_up = 1, c_dn = 1;
  logic [3:0] lo_q, hi_q;
  logic       lo_c, lo_b, hi_c, hi_b;

  bcd_decade_updown #(.STB_STAGES(STG)) u_lo (
    .clk(clk), .clr(c_clr), .load_n(1'b1), .load_val(4'd0),
    .up_stb(c_up), .dn_stb(c_dn), .digit(lo_q), .carry_n(lo_c), .borrow_n(lo_b));
  bcd_decade_updown #(.STB_STAGES(STG)) u_hi (
    .clk(clk), .clr(c_clr), .load_n(1'b1), .load_val(4'd0),
    .up_stb(lo_c), .dn_stb(lo_b), .digit(hi_q), .carry_n(hi_c), .borrow_n(hi_b));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_load(logic [3:0] v);
    load_n = 0; dv = v; tick(1);
    load_n = 1; tick(1);
  endtask

  task automatic do_clr();
    clr = 1; #1;
    chk("R1 async clear", {4'd0, q}, 8'd0);
    tick(1); clr = 0; tick(1);
  endtask

  initial begin
    tick(2);
    chk("R1 reset digit", {4'd0, q}, 8'd0);
    chk("R7 reset borrow_n", {7'd0, bn}, 8'd1);
    clr = 0; c_clr = 0; tick(1);

    // table walk: R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][11:10];
      case (op)
        2'd0: do_clr();
        2'd1: do_load(VEC[i][9:6]);
        2'd2: begin
          up = 0; tick(LAT);
          chk("R6 carry_n mid up", {7'd0, cn}, {7'd0, VEC[i][1]});
          chk("R7 borrow_n mid up", {7'd0, bn}, {7'd0, VEC[i][0]});
          up = 1; tick(LAT);
        end
        default: begin
          dn = 0; tick(LAT);
          chk("R6 carry_n mid down", {7'd0, cn}, {7'd0, VEC[i][1]});
          chk("R7 borrow_n mid down", {7'd0, bn}, {7'd0, VEC[i][0]});
          dn = 1; tick(LAT);
        end
      endcase
      chk(op == 2'd3 ? "R4 digit" : "R3 digit", {4'd0, q}, {4'd0, VEC[i][5:2]});
      chk("R6 carry_n idle", {7'd0, cn}, 8'd1);
      chk("R7 borrow_n idle", {7'd0, bn}, 8'd1);
    end

    // R10 latency
    do_load(4'd4);
    up = 0; tick(LAT);
    up = 1; tick(1);
    chk("R10 no step after one edge", {4'd0, q}, 8'd4);
    tick(1);
    chk("R10 step on second edge", {4'd0, q}, 8'd5);

    // R2 load holds off counting
    load_n = 0; dv = 4'd3; tick(1);
    chk("R2 load value", {4'd0, q}, 8'd3);
    up = 0; tick(LAT); up = 1; tick(LAT);
    dn = 0; tick(LAT); dn = 1; tick(LAT);
    chk("R2 strobes ignored during load", {4'd0, q}, 8'd3);
    load_n = 1; tick(1);

    // R1 clear overrides load and strobes
    load_n = 0; dv = 4'd6; up = 0; tick(1);
    clr = 1; #1;
    chk("R1 clear immediate", {4'd0, q}, 8'd0);
    up = 1; tick(LAT + 1);
    chk("R1 clear overrides load", {4'd0, q}, 8'd0);
    load_n = 1; clr = 0; tick(2);
    chk("R1 zero after release", {4'd0, q}, 8'd0);

    // R5 simultaneous rise
    do_load(4'd5);
    up = 0; dn = 0; tick(LAT);
    up = 1; dn = 1; tick(LAT);
    chk("R5 both strobes hold", {4'd0, q}, 8'd5);

    // R6 carry ignores down strobe at 9
    do_load(4'd9);
    dn = 0; tick(LAT);
    chk("R6 carry_n with down low", {7'd0, cn}, 8'd1);
    chk("R7 borrow_n at nine", {7'd0, bn}, 8'd1);
    dn = 1; tick(LAT);
    chk("R4 nine down to eight", {4'd0, q}, 8'd8);

    // R8 out-of-range loads
    do_load(4'd12); up = 0; tick(LAT); up = 1; tick(LAT);
    chk("R8 up from 12", {4'd0, q}, 8'd0);
    do_load(4'd14); dn = 0; tick(LAT); dn = 1; tick(LAT);
    chk("R8 down from 14", {4'd0, q}, 8'd9);
    do_load(4'd15); up = 0; tick(LAT); up = 1; tick(LAT);
    chk("R8 up from 15", {4'd0, q}, 8'd0);
    do_load(4'd10); dn = 0; tick(LAT); dn = 1; tick(LAT);
    chk("R8 down from 10", {4'd0, q}, 8'd9);

    // R9 two-digit chain
    for (int k = 0; k < 15; k++) begin
      c_up = 0; tick(LAT); c_up = 1; tick(LAT);
    end
    tick(6);
    chk("R9 chain up low digit", {4'd0, lo_q}, 8'd5);
    chk("R9 chain up high digit", {4'd0, hi_q}, 8'd1);
    for (int k = 0; k < 20; k++) begin
      c_dn = 0; tick(LAT); c_dn = 1; tick(LAT);
    end
    tick(6);
    chk("R9 chain down low digit", {4'd0, lo_q}, 8'd5);
    chk("R9 chain down high digit", {4'd0, hi_q}, 8'd9);
    for (int k = 0; k < 5; k++) begin
      c_up = 0; tick(LAT); c_up = 1; tick(LAT);
    end
    tick(6);
    chk("R9 wrap to 00 low digit", {4'd0, lo_q}, 8'd0);
    chk("R9 wrap to 00 high digit", {4'd0, hi_q}, 8'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule